// File: doc/BRIEF.md
# Serial Write-Only Register Bank Slave

This block receives write frames on three wires (a serial clock, an active-low frame enable and a serial data line) and stores them in eight 16-bit registers. Every frame is a 3-bit register index followed by a 16-bit value, both sent most significant bit first. A frame that completes writes the value into the indexed register. Nothing can be read back over the wires. All eight registers are always driven out in parallel.

A write is accepted only after at least one clock edge with the enable line high. That high edge arms the receiver. The receiver shifts 19 bits, then needs a 20th edge with enable still low to commit the word. Two control fields are decoded from register 0, and the two compensation words are driven out on their own ports. Every state change happens on the rising edge of the serial clock.

Top module: `serial_reg_slave`

## Requirements
- R1: While `rst_n` is low at a rising edge of `ser_clk`, all eight registers clear to zero and the receiver is left unarmed.
- R2: A frame is accepted only if at least one rising edge with `frame_en_n` high came after reset or after the previous commit. Low cycles that follow reset directly write nothing.
- R3: The bits sampled on the first three low edges form the register index, sent bit 2 first. The next sixteen low edges carry the data, sent bit 15 first. Register k appears on `regs_flat[16*k+15:16*k]`.
- R4: The addressed register changes only on the 20th consecutive low edge. After 19 low edges its contents are unchanged.
- R5: If `frame_en_n` returns high before the 20th low edge, the frame is dropped and no register changes.
- R6: Once a frame has committed, further low edges are ignored. No second write happens until `frame_en_n` has been high for at least one edge.
- R7: A write changes only the register it addresses.
- R8: `rate_sel` equals bits 13:12 of register 0 (00 below 125 Msps, 01 for 125 to 250, 10 for 250 to 500, 11 above 500).
- R9: `cal_mode` equals bits 11:10 of register 0 (00 means no calibration and default values; 01 means keep the last calculated values).
- R10: `offset_comp` mirrors register 2 and `gain_comp` mirrors register 3.
- R11: Two frames separated by exactly one high edge both commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial clock. All sampling and updates happen on its rising edge. |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en_n | input | 1 | Active-low frame enable. It is high when no write is in progress. |
| ser_din | input | 1 | Serial data, sent MSB first |
| regs_flat | output | 128 | All eight registers; register k is at bits 16k+15:16k |
| rate_sel | output | 2 | Timing select field from register 0, bits 13:12 |
| cal_mode | output | 2 | Calibration mode field from register 0, bits 11:10 |
| offset_comp | output | 16 | Register 2 contents |
| gain_comp | output | 16 | Register 3 contents |

## Verification
The assertions assume that `frame_en_n` and `ser_din` are settled well before each rising edge. They also assume that reset is applied at the first clock edge, so the state is known before any property is enabled. The bench meets both assumptions. It changes the inputs only on falling edges, and it holds reset low for several edges from time zero. The stimulus makes the line misbehave only in the ways the requirements cover: frames with no arming edge, frames cut short, and frames held low too long. It never sends glitches between clock edges.

// File: rtl/serial_reg_pkg.sv
// Package: serial_reg_pkg
// Shared sizes and the write-request type used by the serial register slave.
// Assumes a fixed frame layout of index bits followed by data bits.
package serial_reg_pkg;
    localparam int IDX_W  = 3;
    localparam int WORD_W = 16;
    localparam int NREGS  = 2 ** IDX_W;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
    } wr_req_t;
endpackage

// File: rtl/serial_frame_rx.sv
// Module: serial_frame_rx
// Shifts in one frame (index bits, then data bits, MSB first) and raises a
// write request on the extra low edge that follows the last data bit.
// Assumes the inputs are stable around each rising edge of clk. The receiver
// must see a high frame-enable edge to arm before it accepts a frame.
module serial_frame_rx
    import serial_reg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en_n,
    input  logic    din,
    output wr_req_t req
);
    localparam int SHIFT_W = IDX_W + WORD_W;
    localparam int CNT_W   = $clog2(SHIFT_W + 1);

    logic               armed;
    logic [CNT_W-1:0]   bit_cnt;
    logic [SHIFT_W-1:0] shreg;
    logic               commit;

    // Commit on the low edge that follows a full shift while still armed.
    assign commit = !en_n && armed && (bit_cnt == CNT_W'(SHIFT_W));

    // Arming, bit counting and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (en_n) begin
            armed   <= 1'b1;
            bit_cnt <= '0;
        end else if (armed) begin
            if (bit_cnt == CNT_W'(SHIFT_W)) begin
                armed   <= 1'b0;
                bit_cnt <= '0;
            end else begin
                shreg   <= {shreg[SHIFT_W-2:0], din};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Present the request to the register bank.
    always_comb begin
        req.valid = commit;
        req.idx   = shreg[SHIFT_W-1 -: IDX_W];
        req.word  = shreg[WORD_W-1:0];
    end

    // R2: low edges while unarmed leave the receiver idle and unchanged.
    assert_unarmed_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !armed) |=> (!armed && $stable(shreg)));

    // R4: a request can never come on the edge right after an idle edge.
    assert_no_early_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> !req.valid);

    // R6: two commits never come on consecutive edges.
    assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req.valid |=> !req.valid);
endmodule

// File: rtl/serial_reg_bank.sv
// Module: serial_reg_bank
// Holds the register array and applies one write request per clock.
// Assumes at most one request is valid at a time. There is no read path.
module serial_reg_bank
    import serial_reg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  wr_req_t                 req,
    output logic [NREGS*WORD_W-1:0] regs_flat
);
    logic [WORD_W-1:0] regs [NREGS];

    genvar g;
    generate
        for (g = 0; g < NREGS; g++) begin : g_reg
            // Each register loads only when the request addresses it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (req.valid && req.idx == IDX_W'(g))
                    regs[g] <= req.word;
            end
            assign regs_flat[g*WORD_W +: WORD_W] = regs[g];
        end
    endgenerate

    // R5: without a request no register changes.
    assert_hold_without_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req.valid |=> $stable(regs_flat));

    // R4: after a request the addressed register holds the requested word.
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req.valid |=> (regs[$past(req.idx)] == $past(req.word)));
endmodule

// File: rtl/serial_ctrl_decode.sv
// Module: serial_ctrl_decode
// Extracts the timing-select and calibration-mode fields from the control
// register, and passes the two compensation registers through.
// Assumes the field positions given by its parameters.
module serial_ctrl_decode
    import serial_reg_pkg::*;
#(
    parameter int CTRL_IDX = 0,
    parameter int RATE_LSB = 12,
    parameter int CAL_LSB  = 10,
    parameter int OFFS_IDX = 2,
    parameter int GAIN_IDX = 3
) (
    input  logic [NREGS*WORD_W-1:0] regs_flat,
    output logic [1:0]              rate_sel,
    output logic [1:0]              cal_mode,
    output logic [WORD_W-1:0]       offset_comp,
    output logic [WORD_W-1:0]       gain_comp
);
    logic [WORD_W-1:0] ctrl_word;

    // Field extraction, purely combinational.
    always_comb begin
        ctrl_word   = regs_flat[CTRL_IDX*WORD_W +: WORD_W];
        rate_sel    = ctrl_word[RATE_LSB +: 2];
        cal_mode    = ctrl_word[CAL_LSB +: 2];
        offset_comp = regs_flat[OFFS_IDX*WORD_W +: WORD_W];
        gain_comp   = regs_flat[GAIN_IDX*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/serial_reg_slave.sv
// Module: serial_reg_slave
// Top level of the write-only serial register slave: the frame receiver,
// the register bank and the control-field decode.
// Assumes one clock domain (ser_clk). Outputs are not synchronised to any
// other clock.
module serial_reg_slave
    import serial_reg_pkg::*;
(
    input  logic                    ser_clk,
    input  logic                    rst_n,
    input  logic                    frame_en_n,
    input  logic                    ser_din,
    output logic [NREGS*WORD_W-1:0] regs_flat,
    output logic [1:0]              rate_sel,
    output logic [1:0]              cal_mode,
    output logic [WORD_W-1:0]       offset_comp,
    output logic [WORD_W-1:0]       gain_comp
);
    wr_req_t req;

    serial_frame_rx u_rx (
        .clk   (ser_clk),
        .rst_n (rst_n),
        .en_n  (frame_en_n),
        .din   (ser_din),
        .req   (req)
    );

    serial_reg_bank u_bank (
        .clk       (ser_clk),
        .rst_n     (rst_n),
        .req       (req),
        .regs_flat (regs_flat)
    );

    serial_ctrl_decode u_dec (
        .regs_flat   (regs_flat),
        .rate_sel    (rate_sel),
        .cal_mode    (cal_mode),
        .offset_comp (offset_comp),
        .gain_comp   (gain_comp)
    );

    // R8: the timing select moves only after a write to register 0.
    assert_rate_stable_R8: assert property (@(posedge ser_clk) disable iff (!rst_n)
        !(req.valid && req.idx == '0) |=> $stable(rate_sel));

    // R10: the gain word moves only after a write to register 3.
    assert_gain_stable_R10: assert property (@(posedge ser_clk) disable iff (!rst_n)
        !(req.valid && req.idx == IDX_W'(3)) |=> $stable(gain_comp));
endmodule

// File: tb/serial_reg_slave_test.sv
module serial_reg_slave_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en_n = 1'b0;
    logic         din = 1'b0;
    logic [127:0] regs_flat;
    logic [1:0]   rate_sel, cal_mode;
    logic [15:0]  offset_comp, gain_comp;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] exp_regs [8];

    always #5 clk = ~clk;

    serial_reg_slave uut (
        .ser_clk(clk), .rst_n(rst_n), .frame_en_n(en_n), .ser_din(din),
        .regs_flat(regs_flat), .rate_sel(rate_sel), .cal_mode(cal_mode),
        .offset_comp(offset_comp), .gain_comp(gain_comp)
    );

    function automatic logic [15:0] reg_at(int k);
        return regs_flat[k*16 +: 16];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < 8; k++) check(req, reg_at(k), exp_regs[k]);
    endtask

    // Drive one frame: an optional arming high edge, then n_low low edges.
    // Bits after the 19th are filled with ones.
    task automatic send(input bit pre_high, input logic [2:0] idx,
                        input logic [15:0] word, input int n_low);
        logic [18:0] fr;
        fr = {idx, word};
        if (pre_high) begin
            en_n = 1'b1;
            @(negedge clk);
        end
        for (int i = 0; i < n_low; i++) begin
            en_n = 1'b0;
            din  = (i < 19) ? fr[18-i] : 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic test_reset;
        for (int k = 0; k < 8; k++) exp_regs[k] = '0;
        check_all("R1");
        check("R1", {14'd0, rate_sel}, 16'd0);
    endtask

    task automatic test_unarmed;
        send(0, 3'd5, 16'hAAAA, 20);
        check_all("R2");
    endtask

    task automatic test_commit_timing;
        send(1, 3'd1, 16'h1234, 19);
        check("R4", reg_at(1), 16'h0000);
        send(0, 3'd1, 16'h1234, 0);
        en_n = 1'b0; din = 1'b0; @(negedge clk);
        exp_regs[1] = 16'h1234;
        check("R3", reg_at(1), 16'h1234);
        check_all("R7");
    endtask

    task automatic test_ctrl_fields;
        send(1, 3'd0, 16'h3400, 20);
        exp_regs[0] = 16'h3400;
        check("R8", {14'd0, rate_sel}, 16'd3);
        check("R9", {14'd0, cal_mode}, 16'd1);
        send(1, 3'd0, 16'h1800, 20);
        exp_regs[0] = 16'h1800;
        check("R8", {14'd0, rate_sel}, 16'd1);
        check("R9", {14'd0, cal_mode}, 16'd2);
        check_all("R7");
    endtask

    task automatic test_comp_regs;
        send(1, 3'd2, 16'h5A0F, 20);
        send(1, 3'd3, 16'hC3E1, 20);
        exp_regs[2] = 16'h5A0F;
        exp_regs[3] = 16'hC3E1;
        check("R10", offset_comp, 16'h5A0F);
        check("R10", gain_comp, 16'hC3E1);
    endtask

    task automatic test_abort;
        send(1, 3'd6, 16'hBEEF, 12);
        en_n = 1'b1; @(negedge clk);
        check_all("R5");
        send(1, 3'd6, 16'hBEEF, 19);
        en_n = 1'b1; @(negedge clk);
        check_all("R5");
    endtask

    task automatic test_overrun;
        send(1, 3'd4, 16'h0F0F, 26);
        exp_regs[4] = 16'h0F0F;
        check("R6", reg_at(4), 16'h0F0F);
        check_all("R6");
    endtask

    task automatic test_back_to_back;
        send(1, 3'd6, 16'h1111, 20);
        send(1, 3'd7, 16'h2222, 20);
        exp_regs[6] = 16'h1111;
        exp_regs[7] = 16'h2222;
        check("R11", reg_at(6), 16'h1111);
        check("R11", reg_at(7), 16'h2222);
        check_all("R11");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset;
        rst_n = 1'b1;
        test_unarmed;
        test_commit_timing;
        test_ctrl_fields;
        test_comp_regs;
        test_abort;
        test_overrun;
        test_back_to_back;
        en_n = 1'b1;
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule